// File: doc/BRIEF.md
# Linked-List DMA Chain Walker

This block follows a chain of command packets held in main memory and hands each packet's payload words, one at a time, to a peripheral command port. A node starts with one header word. The top byte of the header is the number of 32-bit payload words stored right after it. The low 24 bits point to the next node. A walk begins on a one-cycle start strobe carrying a start address. The block then fetches headers and payload through a single-outstanding memory read port, and sends the payload on a valid/ready stream.

The walk stops in one of three ways:
- a next pointer with bit 23 set is a terminator, whatever its other bits hold;
- a three-register address guard detects that the walk has come back to a node;
- a node-count ceiling stops a runaway walk.

When the walk stops, a one-cycle done pulse reports the cause. The running total of words fetched is presented alongside the pulse.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset `busy`, `mem_req`, `pay_valid` and `done` are 0 and `word_count` is 0.
- R2: Every node address, including the start address, is masked to a word-aligned address inside a 2^ADDR_W byte space: bits [1:0] cleared and bits above ADDR_W-1 dropped. With the default ADDR_W = 21 this mask is 0x1FFFFC. The first memory read of a walk is the header at the masked start address.
- R3: Header bits [31:24] give N, the payload length in words. Header bits [23:0] give the next pointer. The N words at node+4, node+8, ... are sent in increasing address order. A word transfers when `pay_valid` and `pay_ready` are both high. While `pay_ready` is low, `pay_valid` stays high and `pay_data` does not change.
- R4: After a node's payload has been sent, a next pointer with bit 23 set ends the walk with cause code 1 (terminator), for any value of its other bits.
- R5: A guard holds three 24-bit values (last, backward, forward), each set to 0xFFFFFF at the start of a walk. Before a node is fetched, the walk ends with cause code 2 (loop) if the node address equals the backward or forward value. Otherwise the address replaces the backward value when it is below last, or the forward value when it is not, and then becomes last. The repeated node is not fetched.
- R6: Once MAX_NODES nodes have been fetched, the next node is not fetched and the walk ends with cause code 3 (limit). A chain of exactly MAX_NODES nodes whose last pointer is a terminator ends with code 1.
- R7: `word_count` is set to 1 at start, and each fetched node adds N+1 to it. Its final value is valid while `done` is high and stays until the next start.
- R8: `done` is high for exactly one cycle per walk, with `done_cause` valid in that cycle. `busy` is high from the cycle after an accepted start until the walk ends. A start strobe while `busy` is high is ignored.
- R9: `mem_req` is a one-cycle pulse, and no new request is issued until the response (`mem_rvalid`) to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins a walk when idle |
| start_addr | input | 24 | Address of the first node (masked before use) |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Word-aligned read byte address |
| mem_rvalid | input | 1 | Read data valid, one pulse per request |
| mem_rdata | input | 32 | Read data |
| pay_valid | output | 1 | Payload word available |
| pay_data | output | 32 | Payload word |
| pay_ready | input | 1 | Command port accepts the payload word |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_cause | output | 2 | 1 terminator, 2 loop, 3 limit |
| word_count | output | CNT_W | Total words fetched, including the initial pointer |

## Verification
The embedded assertions check the local protocol rules on every cycle:
- the single-cycle read pulse, the single-outstanding request rule and address alignment;
- payload hold under back-pressure;
- the single-cycle done pulse with a nonzero cause;
- the guard recording each committed address;
- the tally restarting at one.

Only the bench's scenarios can show that a whole walk visits the right nodes and ends for the right reason with the right count. These scenarios cover terminator values other than 0xFFFFFF, forward and backward loops, the ceiling and the list one node short of it, masking of a wild start address, and a 255-word packet under several back-pressure patterns.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
   localparam int PTR_W  = 24;
   localparam int WORD_W = 32;
   localparam int LEN_W  = 8;

   typedef enum logic [1:0] {
      END_NONE  = 2'd0,
      END_TERM  = 2'd1,
      END_LOOP  = 2'd2,
      END_LIMIT = 2'd3
   } end_cause_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CHECK,
      S_HREQ,
      S_HWAIT,
      S_PREQ,
      S_PWAIT,
      S_PSEND,
      S_NEXT
   } walk_state_e;
endpackage

// File: rtl/dcw_loop_guard.sv
module dcw_loop_guard #(
   parameter int PTR_W  = 24,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [PTR_W-1:0] chk_addr,
   input  logic             commit,
   output logic             hit
);
   localparam logic [PTR_W-1:0] SENTINEL = {PTR_W{1'b1}};

   initial begin : p_param_chk
      assert (PTR_W >= 8) else $error("dcw_loop_guard: PTR_W too small");
   end

   generate
      if (ENABLE) begin : g_guard
         logic [PTR_W-1:0] last_q, back_q, fwd_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_q <= SENTINEL;
               back_q <= SENTINEL;
               fwd_q  <= SENTINEL;
            end else if (clear) begin
               last_q <= SENTINEL;
               back_q <= SENTINEL;
               fwd_q  <= SENTINEL;
            end else if (commit) begin
               if (chk_addr < last_q) back_q <= chk_addr;
               else                   fwd_q  <= chk_addr;
               last_q <= chk_addr;
            end
         end

         assign hit = (chk_addr == back_q) || (chk_addr == fwd_q);

         // R5: a committed address becomes the new "last" value
         assert_guard_records_R5: assert property (@(posedge clk) disable iff (!rst_n)
            commit && !clear |=> last_q == $past(chk_addr));
         // R5: a committed address matches back or forward afterwards
         assert_guard_hit_after_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            commit && !clear |=> (back_q == $past(chk_addr)) || (fwd_q == $past(chk_addr)));
      end else begin : g_no_guard
         logic unused_guard;
         assign unused_guard = ^{clk, rst_n, clear, chk_addr, commit};
         assign hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dcw_word_tally.sv
module dcw_word_tally #(
   parameter int CNT_W    = 32,
   parameter int ADD_W    = 9,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [ADD_W-1:0] add_val,
   output logic [CNT_W-1:0] count
);
   initial begin : p_param_chk
      assert (CNT_W > ADD_W) else $error("dcw_word_tally: CNT_W must exceed ADD_W");
   end

   logic [CNT_W:0]   sum_wide;
   logic [CNT_W-1:0] next_val;

   assign sum_wide = {1'b0, count} + {{(CNT_W + 1 - ADD_W){1'b0}}, add_val};

   generate
      if (SATURATE) begin : g_sat
         assign next_val = sum_wide[CNT_W] ? {CNT_W{1'b1}} : sum_wide[CNT_W-1:0];
      end else begin : g_wrap
         assign next_val = sum_wide[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (clr)    count <= CNT_W'(1);
      else if (add_en) count <= next_val;
   end

   // R7: every walk starts its tally at one for the initial pointer
   assert_tally_starts_at_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == CNT_W'(1));
   // R7: the tally never decreases while adding
   assert_tally_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
      add_en && !clr |=> count >= $past(count));
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
   import dcw_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int MAX_NODES  = 2000000,
   parameter int CNT_W      = 32,
   parameter bit LOOP_GUARD = 1'b1,
   parameter bit SAT_COUNT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [23:0]       start_addr,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              pay_valid,
   output logic [31:0]       pay_data,
   input  logic              pay_ready,
   output logic              done,
   output logic [1:0]        done_cause,
   output logic [CNT_W-1:0]  word_count
);
   localparam int NODE_W = $clog2(MAX_NODES + 1);
   localparam int ADD_W  = LEN_W + 1;
   localparam int HI_PAD = PTR_W - ADDR_W;
   localparam logic [NODE_W-1:0] NODE_CAP = NODE_W'(MAX_NODES);
   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

   initial begin : p_param_chk
      assert (ADDR_W >= 3 && ADDR_W <= 23) else $error("ADDR_W out of range");
      assert (MAX_NODES >= 1) else $error("MAX_NODES must be positive");
      assert (CNT_W > ADD_W) else $error("CNT_W too narrow");
   end

   walk_state_e       state_q;
   end_cause_e        cause_q;
   logic [ADDR_W-1:0] node_q, pay_addr_q;
   logic [LEN_W-1:0]  remain_q;
   logic [PTR_W-1:0]  next_q;
   logic [NODE_W-1:0] nodes_q;
   logic [WORD_W-1:0] pay_q;
   logic              done_q;

   logic              accept;
   logic              at_cap;
   logic              guard_hit;
   logic              guard_commit;
   logic [LEN_W-1:0]  hdr_len;
   logic              unused_bits;

   assign accept   = (state_q == S_IDLE) && start;
   assign at_cap   = (nodes_q == NODE_CAP);
   assign hdr_len  = mem_rdata[WORD_W-1 -: LEN_W];
   assign guard_commit = (state_q == S_CHECK) && !at_cap && !guard_hit;
   assign unused_bits  = ^{start_addr[PTR_W-1:ADDR_W], start_addr[1:0],
                           next_q[PTR_W-2:ADDR_W], next_q[1:0]};

   dcw_loop_guard #(
      .PTR_W  (PTR_W),
      .ENABLE (LOOP_GUARD)
   ) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .chk_addr ({{HI_PAD{1'b0}}, node_q}),
      .commit   (guard_commit),
      .hit      (guard_hit)
   );

   dcw_word_tally #(
      .CNT_W    (CNT_W),
      .ADD_W    (ADD_W),
      .SATURATE (SAT_COUNT)
   ) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .add_en  ((state_q == S_HWAIT) && mem_rvalid),
      .add_val ({1'b0, hdr_len} + ADD_W'(1)),
      .count   (word_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         cause_q    <= END_NONE;
         node_q     <= '0;
         pay_addr_q <= '0;
         remain_q   <= '0;
         next_q     <= '0;
         nodes_q    <= '0;
         pay_q      <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start) begin
                  node_q  <= {start_addr[ADDR_W-1:2], 2'b00};
                  nodes_q <= '0;
                  state_q <= S_CHECK;
               end
            end
            S_CHECK: begin
               if (at_cap) begin
                  cause_q <= END_LIMIT;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else if (guard_hit) begin
                  cause_q <= END_LOOP;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  nodes_q <= nodes_q + NODE_W'(1);
                  state_q <= S_HREQ;
               end
            end
            S_HREQ: state_q <= S_HWAIT;
            S_HWAIT: begin
               if (mem_rvalid) begin
                  remain_q   <= hdr_len;
                  next_q     <= mem_rdata[PTR_W-1:0];
                  pay_addr_q <= node_q + WORD_STEP;
                  state_q    <= (hdr_len == '0) ? S_NEXT : S_PREQ;
               end
            end
            S_PREQ: state_q <= S_PWAIT;
            S_PWAIT: begin
               if (mem_rvalid) begin
                  pay_q   <= mem_rdata;
                  state_q <= S_PSEND;
               end
            end
            S_PSEND: begin
               if (pay_ready) begin
                  remain_q   <= remain_q - LEN_W'(1);
                  pay_addr_q <= pay_addr_q + WORD_STEP;
                  state_q    <= (remain_q == LEN_W'(1)) ? S_NEXT : S_PREQ;
               end
            end
            S_NEXT: begin
               if (next_q[PTR_W-1]) begin
                  cause_q <= END_TERM;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  node_q  <= {next_q[ADDR_W-1:2], 2'b00};
                  state_q <= S_CHECK;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != S_IDLE);
   assign mem_req    = (state_q == S_HREQ) || (state_q == S_PREQ);
   assign mem_addr   = (state_q == S_HREQ) ? node_q : pay_addr_q;
   assign pay_valid  = (state_q == S_PSEND);
   assign pay_data   = pay_q;
   assign done       = done_q;
   assign done_cause = cause_q;

   // R9: read request lasts a single cycle
   assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R9: no request between a request and its response
   assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req && (busy || mem_rvalid));
   // R2: read addresses are word aligned
   assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);
   // R3: payload held steady under back-pressure
   assert_pay_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid && !pay_ready |=> pay_valid && $stable(pay_data));
   // R8: done is a single-cycle pulse
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: a reported end always carries a cause and leaves the block idle
   assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_cause != 2'd0 && !busy);
   // R8: a start while busy does not restart the walk
   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> busy || done);
endmodule

// File: tb/dma_chain_walker_tb.sv
`timescale 1ns/1ps
module dma_chain_walker_tb;
   localparam int ADDR_W = 21;
   localparam int LIM    = 8;
   localparam int NV     = 9;

   // vector table: start address, expected cause, expected count, ready mode
   localparam logic [23:0] V_ADDR [NV] = '{24'h000100, 24'h000400, 24'h000500,
      24'hE00701, 24'h000A00, 24'h000C00, 24'h000D00, 24'h001000, 24'h001600};
   localparam int V_CAUSE [NV] = '{1, 1, 2, 1, 3, 1, 1, 1, 2};
   localparam int V_COUNT [NV] = '{9, 3, 4, 5, 9, 9, 2, 257, 4};
   localparam int V_MODE  [NV] = '{0, 1, 1, 2, 0, 1, 0, 2, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [23:0] start_addr = '0;
   logic busy, mem_req, pay_valid, done;
   logic [ADDR_W-1:0] mem_addr;
   logic mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] pay_data;
   logic pay_ready = 1'b0;
   logic [1:0] done_cause;
   logic [31:0] word_count;

   always #4 clk = ~clk;

   dma_chain_walker #(.ADDR_W(ADDR_W), .MAX_NODES(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
      .done(done), .done_cause(done_cause), .word_count(word_count));

   logic [31:0] mem [0:2047];
   logic [31:0] exp_pay [0:511];
   int exp_n, rx_idx, mism, done_cycles, viol, pend, cyc, ready_mode;
   int checks = 0, errors = 0;
   bit done_seen, first_seen;
   int got_cause, got_count;
   logic [ADDR_W-1:0] first_addr;
   logic p1 = 1'b0;
   logic [ADDR_W-1:0] a1 = '0;

   // two-cycle memory model with outstanding-request monitor
   always @(posedge clk) begin
      if (mem_req && pend != 0) viol <= viol + 1;
      pend <= pend + (mem_req ? 1 : 0) - (mem_rvalid ? 1 : 0);
      p1 <= mem_req;
      a1 <= mem_addr;
      mem_rvalid <= p1;
      mem_rdata  <= mem[a1[12:2]];
   end

   always @(negedge clk) begin
      cyc <= cyc + 1;
      case (ready_mode)
         0: pay_ready = 1'b1;
         1: pay_ready = cyc[0];
         default: pay_ready = (cyc % 4) != 0;
      endcase
      if (pay_valid && pay_ready) begin
         if (rx_idx >= exp_n || pay_data !== exp_pay[rx_idx]) mism = mism + 1;
         rx_idx = rx_idx + 1;
      end
      if (mem_req && !first_seen) begin
         first_seen = 1'b1;
         first_addr = mem_addr;
      end
      if (done) begin
         done_seen   = 1'b1;
         done_cycles = done_cycles + 1;
         got_cause   = int'(done_cause);
         got_count   = int'(word_count);
      end
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog R8 actual=%0d expected=<150000 cycles", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // independent model of the walk, written from the requirements
   task automatic model(input logic [23:0] sa, output int cause, output int cnt);
      logic [23:0] a, last, back, fwd, h;
      int nodes;
      a = sa & 24'h1FFFFC;
      last = 24'hFFFFFF; back = 24'hFFFFFF; fwd = 24'hFFFFFF;
      nodes = 0; cnt = 1; exp_n = 0; cause = 0;
      while (cause == 0) begin
         if (nodes == LIM) cause = 3;
         else if (a == back || a == fwd) cause = 2;
         else begin
            if (a < last) back = a; else fwd = a;
            last = a;
            nodes = nodes + 1;
            h = mem[a[12:2]];
            cnt = cnt + int'(mem[a[12:2]][31:24]) + 1;
            for (int k = 1; k <= int'(mem[a[12:2]][31:24]); k++) begin
               exp_pay[exp_n] = mem[11'((int'(a) + 4 * k) >> 2)];
               exp_n = exp_n + 1;
            end
            if (h[23]) cause = 1;
            else a = h & 24'h1FFFFC;
         end
      end
   endtask

   task automatic walk(input logic [23:0] sa, input int mode, input bit poke);
      int t;
      ready_mode = mode;
      rx_idx = 0; mism = 0; done_seen = 0; done_cycles = 0; first_seen = 0;
      @(negedge clk);
      start = 1'b1; start_addr = sa;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1; start_addr = 24'h000400;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (!done_seen && t < 5000) begin
         @(negedge clk);
         t = t + 1;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic hdr(input int addr, input int n, input logic [23:0] nxt);
      mem[addr >> 2] = {8'(n), nxt};
   endtask

   initial begin
      int mc, mn;
      cyc = 0; viol = 0; pend = 0; ready_mode = 0; exp_n = 0;
      for (int i = 0; i < 2048; i++) mem[i] = 32'hC0DE0000 | i;
      hdr(32'h100, 2, 24'h000200); hdr(32'h200, 0, 24'h000300);
      hdr(32'h300, 3, 24'h800000);
      hdr(32'h400, 1, 24'hFFFFFF);
      hdr(32'h500, 1, 24'h000600); hdr(32'h600, 0, 24'h000500);
      hdr(32'h700, 0, 24'h400904); hdr(32'h904, 2, 24'h8ABCDE);
      for (int i = 0; i < 12; i++) hdr(32'hA00 + 16 * i, 0, 24'(32'hA10 + 16 * i));
      for (int i = 0; i < 8; i++)
         hdr(32'hC00 + 16 * i, 0, (i == 7) ? 24'h800000 : 24'(32'hC10 + 16 * i));
      hdr(32'hD00, 0, 24'hFFFFFF);
      hdr(32'h1000, 255, 24'h800000);
      hdr(32'h1600, 0, 24'h001500); hdr(32'h1500, 0, 24'h001580);
      hdr(32'h1580, 0, 24'h001500);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !pay_valid && !done, "R1", "idle outputs in reset",
          {busy, mem_req, pay_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(word_count == 0 && !busy, "R1", "count after reset", word_count, 0);

      for (int v = 0; v < NV; v++) begin
         model(V_ADDR[v], mc, mn);
         walk(V_ADDR[v], V_MODE[v], 1'b0);
         // R4 terminator, R5 loop, R6 limit
         chk(got_cause == V_CAUSE[v] && mc == V_CAUSE[v],
             (V_CAUSE[v] == 1) ? "R4" : (V_CAUSE[v] == 2) ? "R5" : "R6",
             $sformatf("cause vec %0d", v), got_cause, V_CAUSE[v]);
         chk(got_count == V_COUNT[v], "R7", $sformatf("word count vec %0d", v),
             got_count, V_COUNT[v]);
         chk(mism == 0 && rx_idx == exp_n, "R3", $sformatf("payload vec %0d", v),
             rx_idx, exp_n);
         chk(first_addr == ADDR_W'(V_ADDR[v] & 24'h1FFFFC), "R2",
             $sformatf("first header addr vec %0d", v), first_addr,
             V_ADDR[v] & 24'h1FFFFC);
         chk(done_cycles == 1 && !busy, "R8", $sformatf("done pulse vec %0d", v),
             done_cycles, 1);
      end

      // R8: start while busy is ignored
      model(24'h000100, mc, mn);
      walk(24'h000100, 1, 1'b1);
      chk(got_cause == 1 && got_count == 9 && mism == 0 && rx_idx == exp_n && done_cycles == 1,
          "R8", "start while busy ignored", got_count, 9);
      // R7: count held after done
      chk(word_count == 9, "R7", "count held after done", word_count, 9);
      // R9: single outstanding read, over all walks
      chk(viol == 0, "R9", "requests while outstanding", viol, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule